// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

A memory-mapped timer built around one 64-bit up-counter that advances once per clock while a global run bit is set. Several comparator channels watch that counter. Each fires only in the exact clock in which the counter equals its match value. A channel can run once or rearm itself by a programmed period. On a match it raises an edge pulse or a sticky level interrupt, or it emits a message made of a programmed data word and address.

Software reaches every register over a plain 32-bit write/read bus. Reads are combinational from the addressed register. Comparator writes travel through a fixed delay before they land. A global legacy routing bit moves the events of channels 0 and 1 onto two dedicated lines, one for the system tick and one for the real-time clock. Bus bridging and interrupt control sit outside this block.

Top module: `evt_timer`

## Requirements
- R1: The capability word at 0x000 reads with a revision of 1 in [7:0], the channel count minus one in [12:8], 1 in bit 13 (64-bit counter) and 1 in bit 15 (legacy routing available). The word at 0x004 reads the counter period in femtoseconds (20,000,000 by default). Writes to either word have no effect.
- R2: Bit 0 of the global word at 0x010 is the run bit. While it is set, the counter adds one per clock. While it is clear, the counter holds. Bit 1 is the legacy routing bit. Other bits read as 0.
- R3: The counter reads and writes as two halves, low at 0x0F0 and high at 0x0F4.
- R4: A channel is enabled by bit 2 of its configuration word. Channel n occupies 0x100 + 0x20*n: configuration at +0x00, comparator low and high at +0x08 and +0x0C, message data at +0x10, message address at +0x14. An enabled channel fires only in a clock where the run bit is set and the counter exactly equals the comparator. A value the counter has already passed does not fire. In edge mode (bit 1 = 0), the channel's irq_line bit is high for one clock, starting the cycle after the counter held the match value. The counter therefore reads match+1 while the pulse is high.
- R5: A comparator write takes effect two clocks after the bus write. Readback shows the old value until then.
- R6: When bit 3 (periodic) is set, a comparator write landing while bit 6 (set-value) is set loads the match point. A landing low-word write also clears bit 6. Later comparator writes load the period instead. Each match adds the period to the match point.
- R7: With bit 8 (32-bit mode) set, matching compares only the low 32 counter bits, and the periodic addition wraps modulo 2^32.
- R8: Configuration bits 1, 2, 3, 6, 8 and 14 are writable. Bit 3 sticks only on periodic-capable channels (0 and 1 by default). Read-only bits 4 (periodic capable), 5 (64-bit capable) and 15 (message capable) report the channel's capabilities. All other bits read as 0.
- R9: In level mode (bit 1 = 1), a match sets that channel's bit in the status word at 0x020, and irq_line follows the bit. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: With bit 14 (message enable) set, a match raises msg_valid for one clock. It presents the message data word on msg_data and the message address on msg_addr, and irq_line stays low.
- R11: With legacy routing set, channel 0's line appears on legacy_tick_irq and channel 1's line appears on legacy_rtc_irq. irq_line bits 0 and 1 are then held low.
- R12: After reset the counter, global word, status and all channel configurations are zero except capability bits. Comparators read all ones, and every interrupt and message output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_line | output | NUM_CH | Per-channel interrupt line |
| legacy_tick_irq | output | 1 | Channel 0 event under legacy routing |
| legacy_rtc_irq | output | 1 | Channel 1 event under legacy routing |
| msg_valid | output | NUM_CH | Per-channel message strobe |
| msg_addr | output | 32*NUM_CH | Per-channel message address |
| msg_data | output | 32*NUM_CH | Per-channel message data |

## Verification
The bench sets a comparator behind the counter and confirms that nothing fires. A design that matched at-or-past would fire at once. In the periodic handshake the match point and the period are written back to back, and the events must land at 21, 31 and 41. Swapping the two roles, or clearing set-value on the wrong write, shifts every event. The comparator is read back on both sides of the two-clock landing delay, and a 32-bit-mode channel is matched across a low-word wrap that a full 64-bit compare would never reach. Status clearing is written with 0 and then 1, so that a clear-on-any-write design gets caught.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam logic [11:0] A_CAP_LO = 12'h000;
    localparam logic [11:0] A_CAP_HI = 12'h004;
    localparam logic [11:0] A_GCFG   = 12'h010;
    localparam logic [11:0] A_STS    = 12'h020;
    localparam logic [11:0] A_CNT_LO = 12'h0F0;
    localparam logic [11:0] A_CNT_HI = 12'h0F4;

    localparam logic [4:0] O_CFG    = 5'h00;
    localparam logic [4:0] O_CMP_LO = 5'h08;
    localparam logic [4:0] O_CMP_HI = 5'h0C;
    localparam logic [4:0] O_RT_DAT = 5'h10;
    localparam logic [4:0] O_RT_ADR = 5'h14;

    localparam int B_LEVEL  = 1;
    localparam int B_EN     = 2;
    localparam int B_PER    = 3;
    localparam int B_PERCAP = 4;
    localparam int B_64CAP  = 5;
    localparam int B_SETVAL = 6;
    localparam int B_F32    = 8;
    localparam int B_MSGEN  = 14;
    localparam int B_MSGCAP = 15;

    typedef struct packed {
        logic        vld;
        logic        hi;
        logic [31:0] data;
    } cmp_wr_t;

    typedef struct packed {
        logic level;
        logic en;
        logic per;
        logic setval;
        logic f32;
        logic msg_en;
    } ch_cfg_t;

    typedef struct packed {
        logic run;
        logic legacy;
    } gcfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run)   cnt_d = cnt_q + 1'b1;
        if (wr_lo) cnt_d[31:0] = wdata;
        if (wr_hi) cnt_d[CNT_W-1:32] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int   WR_DLY  = 2,
    parameter logic PER_CAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] cnt,
    input  logic        run,
    input  logic        cfg_we,
    input  logic        cmp_we_lo,
    input  logic        cmp_we_hi,
    input  logic        rt_we_dat,
    input  logic        rt_we_adr,
    input  logic [31:0] wdata,
    input  logic        sts_clr,
    output logic [31:0] cfg_rd,
    output logic [63:0] cmp_rd,
    output logic        sts,
    output logic        line_irq,
    output logic        msg_vld,
    output logic [31:0] msg_adr,
    output logic [31:0] msg_dat
);
    typedef struct packed {
        ch_cfg_t                  cfg;
        logic [63:0]              cmp;
        logic [63:0]              per;
        logic [31:0]              rt_dat;
        logic [31:0]              rt_adr;
        logic                     sts;
        logic                     pulse;
        logic                     msg;
        cmp_wr_t [WR_DLY-1:0]     pipe;
    } ch_state_t;

    ch_state_t s_d, s_q;
    cmp_wr_t   land;
    logic      hit;

    assign hit = run && s_q.cfg.en &&
                 (s_q.cfg.f32 ? (cnt[31:0] == s_q.cmp[31:0]) : (cnt == s_q.cmp));
    assign land = s_q.pipe[WR_DLY-1];

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        s_d.msg   = 1'b0;

        if (cfg_we) begin
            s_d.cfg.level  = wdata[B_LEVEL];
            s_d.cfg.en     = wdata[B_EN];
            s_d.cfg.per    = wdata[B_PER] & PER_CAP;
            s_d.cfg.setval = wdata[B_SETVAL];
            s_d.cfg.f32    = wdata[B_F32];
            s_d.cfg.msg_en = wdata[B_MSGEN];
        end
        if (rt_we_dat) s_d.rt_dat = wdata;
        if (rt_we_adr) s_d.rt_adr = wdata;

        s_d.pipe[0] = '{vld: cmp_we_lo | cmp_we_hi, hi: cmp_we_hi, data: wdata};
        for (int k = 1; k < WR_DLY; k++) s_d.pipe[k] = s_q.pipe[k-1];

        if (sts_clr) s_d.sts = 1'b0;

        if (hit) begin
            if (s_q.cfg.msg_en)     s_d.msg   = 1'b1;
            else if (s_q.cfg.level) s_d.sts   = 1'b1;
            else                    s_d.pulse = 1'b1;
            if (s_q.cfg.per) begin
                if (s_q.cfg.f32) s_d.cmp[31:0] = s_q.cmp[31:0] + s_q.per[31:0];
                else             s_d.cmp       = s_q.cmp + s_q.per;
            end
        end

        if (land.vld) begin
            if (s_q.cfg.per && !s_q.cfg.setval) begin
                if (land.hi) s_d.per[63:32] = land.data;
                else         s_d.per[31:0]  = land.data;
            end else begin
                if (land.hi) s_d.cmp[63:32] = land.data;
                else         s_d.cmp[31:0]  = land.data;
                if (s_q.cfg.per && !land.hi) s_d.cfg.setval = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmp <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cfg_rd           = '0;
        cfg_rd[B_LEVEL]  = s_q.cfg.level;
        cfg_rd[B_EN]     = s_q.cfg.en;
        cfg_rd[B_PER]    = s_q.cfg.per;
        cfg_rd[B_PERCAP] = PER_CAP;
        cfg_rd[B_64CAP]  = 1'b1;
        cfg_rd[B_SETVAL] = s_q.cfg.setval;
        cfg_rd[B_F32]    = s_q.cfg.f32;
        cfg_rd[B_MSGEN]  = s_q.cfg.msg_en;
        cfg_rd[B_MSGCAP] = 1'b1;
    end

    assign cmp_rd   = s_q.cmp;
    assign sts      = s_q.sts;
    assign line_irq = s_q.cfg.level ? s_q.sts : s_q.pulse;
    assign msg_vld  = s_q.msg;
    assign msg_adr  = s_q.rt_adr;
    assign msg_dat  = s_q.rt_dat;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH       = 3,
    parameter int          WR_DLY       = 2,
    parameter int unsigned PERIOD_FS    = 20_000_000,
    parameter logic [7:0]  PER_CAP_MASK = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CH-1:0]    irq_line,
    output logic                 legacy_tick_irq,
    output logic                 legacy_rtc_irq,
    output logic [NUM_CH-1:0]    msg_valid,
    output logic [NUM_CH*32-1:0] msg_addr,
    output logic [NUM_CH*32-1:0] msg_data
);
    localparam logic [4:0]  CH_FIELD = 5'(NUM_CH - 1);
    localparam logic [31:0] CAP_LO   = {16'h0, 1'b1, 1'b0, 1'b1, CH_FIELD, 8'h01};
    localparam logic [31:0] CAP_HI   = 32'(PERIOD_FS);

    gcfg_t        g_d, g_q;
    logic         run_w, legacy_w;
    logic [63:0]  cnt_q;
    logic [NUM_CH-1:0] sts_vec, ch_line;
    logic [31:0]  ch_cfg [NUM_CH];
    logic [63:0]  ch_cmp [NUM_CH];
    logic [31:0]  ch_rtd [NUM_CH];
    logic [31:0]  ch_rta [NUM_CH];

    always_comb begin
        g_d = g_q;
        if (bus_we && bus_addr == A_GCFG) begin
            g_d.run    = bus_wdata[0];
            g_d.legacy = bus_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign run_w    = g_q.run;
    assign legacy_w = g_q.legacy;

    evt_counter #(.CNT_W(64)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .wr_lo (bus_we && bus_addr == A_CNT_LO),
        .wr_hi (bus_we && bus_addr == A_CNT_HI),
        .wdata (bus_wdata),
        .cnt   (cnt_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = bus_we && bus_addr[11:8] == 4'h1 && bus_addr[7:5] == 3'(i);

        evt_channel #(.WR_DLY(WR_DLY), .PER_CAP(PER_CAP_MASK[i])) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt_q),
            .run       (run_w),
            .cfg_we    (sel && bus_addr[4:0] == O_CFG),
            .cmp_we_lo (sel && bus_addr[4:0] == O_CMP_LO),
            .cmp_we_hi (sel && bus_addr[4:0] == O_CMP_HI),
            .rt_we_dat (sel && bus_addr[4:0] == O_RT_DAT),
            .rt_we_adr (sel && bus_addr[4:0] == O_RT_ADR),
            .wdata     (bus_wdata),
            .sts_clr   (bus_we && bus_addr == A_STS && bus_wdata[i]),
            .cfg_rd    (ch_cfg[i]),
            .cmp_rd    (ch_cmp[i]),
            .sts       (sts_vec[i]),
            .line_irq  (ch_line[i]),
            .msg_vld   (msg_valid[i]),
            .msg_adr   (msg_addr[i*32 +: 32]),
            .msg_dat   (msg_data[i*32 +: 32])
        );

        if (i < 2) begin : g_leg
            assign irq_line[i] = ch_line[i] & ~legacy_w;
        end else begin : g_std
            assign irq_line[i] = ch_line[i];
        end
    end

    assign legacy_tick_irq = legacy_w & ch_line[0];
    assign legacy_rtc_irq  = legacy_w & ch_line[1];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CAP_LO: bus_rdata = CAP_LO;
            A_CAP_HI: bus_rdata = CAP_HI;
            A_GCFG:   bus_rdata = {30'h0, g_q.legacy, g_q.run};
            A_STS:    bus_rdata = 32'(sts_vec);
            A_CNT_LO: bus_rdata = cnt_q[31:0];
            A_CNT_HI: bus_rdata = cnt_q[63:32];
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (bus_addr[11:8] == 4'h1 && bus_addr[7:5] == 3'(i)) begin
                        case (bus_addr[4:0])
                            O_CFG:    bus_rdata = ch_cfg[i];
                            O_CMP_LO: bus_rdata = ch_cmp[i][31:0];
                            O_CMP_HI: bus_rdata = ch_cmp[i][63:32];
                            O_RT_DAT: bus_rdata = ch_rtd[i];
                            O_RT_ADR: bus_rdata = ch_rta[i];
                            default:  bus_rdata = '0;
                        endcase
                    end
                end
            end
        endcase
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_rt
        assign ch_rtd[i] = msg_data[i*32 +: 32];
        assign ch_rta[i] = msg_addr[i*32 +: 32];
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [11:0]       bus_addr,
    input logic              run_w,
    input logic              legacy_w,
    input logic [63:0]       cnt_q,
    input logic [NUM_CH-1:0] sts_vec,
    input logic [1:0]        irq_lo
);
    logic cnt_wr, sts_wr;
    assign cnt_wr = bus_we && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
    assign sts_wr = bus_we && bus_addr == A_STS;

    // R2: counter holds while stopped
    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !cnt_wr) |=> $stable(cnt_q));

    // R2: counter steps by one while running
    a_r2_step_running: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 64'd1));

    // R9: status bits only drop through a status write
    a_r9_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> (($past(sts_vec) & ~sts_vec) == '0));

    // R11: legacy routing silences the two shared lines
    a_r11_legacy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_w |-> (irq_lo == 2'b00));
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .run_w    (run_w),
    .legacy_w (legacy_w),
    .cnt_q    (cnt_q),
    .sts_vec  (sts_vec),
    .irq_lo   (irq_line[1:0])
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    irq_line;
    logic              legacy_tick_irq, legacy_rtc_irq;
    logic [NCH-1:0]    msg_valid;
    logic [NCH*32-1:0] msg_addr, msg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line),
        .legacy_tick_irq(legacy_tick_irq), .legacy_rtc_irq(legacy_rtc_irq),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // {we, addr, wdata, expected readback}
    localparam int NV = 13;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0,        32'h0000A201},
        {1'b0, 12'h004, 32'h0,        32'h01312D00},
        {1'b1, 12'h000, 32'hFFFFFFFF, 32'h0000A201},
        {1'b1, 12'h004, 32'h0,        32'h01312D00},
        {1'b1, 12'h100, 32'hFFFFFFFF, 32'h0000C17E},
        {1'b1, 12'h100, 32'h0,        32'h00008030},
        {1'b1, 12'h140, 32'hFFFFFFFF, 32'h0000C166},
        {1'b1, 12'h140, 32'h0,        32'h00008020},
        {1'b1, 12'h130, 32'h12345678, 32'h12345678},
        {1'b1, 12'h134, 32'h89ABCDEF, 32'h89ABCDEF},
        {1'b1, 12'h010, 32'hFFFFFFFE, 32'h00000002},
        {1'b1, 12'h0F4, 32'h0000ABCD, 32'h0000ABCD},
        {1'b1, 12'h0F0, 32'h11112222, 32'h11112222}
    };

    function automatic string tag_of(input logic [11:0] a);
        if (a < 12'h010)        return "R1";
        else if (a == 12'h010)  return "R2";
        else if (a >= 12'h0F0 && a < 12'h100) return "R3";
        else if (a[4:0] == 5'h00) return "R8";
        else                    return "R10";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, v2, at;
        int n, nl;
        logic [31:0] seen [3];

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R12 reset state
        rd(12'h0F0, v); chk("R12 counter", 64'(v), 64'h0);
        rd(12'h020, v); chk("R12 status", 64'(v), 64'h0);
        rd(12'h010, v); chk("R12 global", 64'(v), 64'h0);
        rd(12'h108, v); chk("R12 cmp", 64'(v), 64'hFFFFFFFF);
        rd(12'h100, v); chk("R12 cfg", 64'(v), 64'h8030);
        chk("R12 outputs", 64'({irq_line, msg_valid, legacy_tick_irq, legacy_rtc_irq}), 64'h0);

        // table walk: register layout and read-only fields
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
            rd(VEC[i][75:64], v);
            chk(tag_of(VEC[i][75:64]), 64'(v), 64'(VEC[i][31:0]));
        end
        wr(12'h010, 32'h0);

        // R2 hold and run
        rd(12'h0F0, v); idle(5); rd(12'h0F0, v2);
        chk("R2 hold", 64'(v2), 64'(v));
        wr(12'h010, 32'h1);
        rd(12'h0F0, v); idle(5); rd(12'h0F0, v2);
        chk("R2 run", 64'(v2), 64'(v + 32'd5));
        wr(12'h010, 32'h0);

        // R4 one-shot exact match
        wr(12'h0F4, 0); wr(12'h0F0, 0);
        wr(12'h100, 32'h4); wr(12'h10C, 0); wr(12'h108, 32'd50);
        idle(3);
        wr(12'h010, 32'h1);
        bus_addr = 12'h0F0; n = 0; at = '0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (irq_line[0]) begin n++; at = bus_rdata; end
        end
        chk("R4 one pulse", 64'(n), 64'd1);
        chk("R4 pulse cycle", 64'(at), 64'd51);

        // R4 passed value never fires
        wr(12'h010, 0); wr(12'h0F0, 32'd300); wr(12'h108, 32'd100);
        idle(3);
        wr(12'h010, 32'h1);
        n = 0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (irq_line[0]) n++;
        end
        chk("R4 passed value", 64'(n), 64'd0);
        wr(12'h010, 0);

        // R5 delayed comparator write
        wr(12'h108, 32'h77);
        rd(12'h108, v); chk("R5 old at +0", 64'(v), 64'd100);
        @(negedge clk); rd(12'h108, v); chk("R5 old at +1", 64'(v), 64'd100);
        @(negedge clk); rd(12'h108, v); chk("R5 new at +2", 64'(v), 64'h77);

        // R6 periodic set-value handshake
        wr(12'h0F0, 0); wr(12'h0F4, 0);
        wr(12'h100, 32'h4C); wr(12'h10C, 0); wr(12'h108, 32'd20); wr(12'h108, 32'd10);
        idle(4);
        wr(12'h010, 32'h1);
        bus_addr = 12'h0F0; n = 0;
        for (int c = 0; c < 100 && n < 3; c++) begin
            @(negedge clk);
            if (irq_line[0]) begin seen[n] = bus_rdata; n++; end
        end
        chk("R6 event count", 64'(n), 64'd3);
        chk("R6 first", 64'(seen[0]), 64'd21);
        chk("R6 second", 64'(seen[1]), 64'd31);
        chk("R6 third", 64'(seen[2]), 64'd41);

        // R11 tick routing
        wr(12'h010, 32'h3);
        n = 0; nl = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (legacy_tick_irq) n++;
            if (irq_line[0]) nl++;
        end
        chk("R11 tick pulses", 64'(n >= 3), 64'd1);
        chk("R11 line0 quiet", 64'(nl), 64'd0);
        wr(12'h010, 0); wr(12'h100, 0);

        // R9 level status
        wr(12'h0F0, 0); wr(12'h0F4, 0);
        wr(12'h140, 32'h6); wr(12'h14C, 0); wr(12'h148, 32'd5);
        idle(3);
        wr(12'h010, 32'h1);
        idle(20);
        rd(12'h020, v); chk("R9 status set", 64'(v), 64'h4);
        chk("R9 level line", 64'(irq_line[2]), 64'd1);
        wr(12'h020, 32'h0);
        rd(12'h020, v); chk("R9 zero write kept", 64'(v), 64'h4);
        wr(12'h020, 32'h4);
        rd(12'h020, v); chk("R9 cleared", 64'(v), 64'h0);
        chk("R9 line low", 64'(irq_line[2]), 64'd0);

        // R10 message delivery
        wr(12'h010, 0); wr(12'h140, 0); wr(12'h0F0, 0);
        wr(12'h120, 32'h4004); wr(12'h130, 32'hDEAD0001); wr(12'h134, 32'hFEE00010);
        wr(12'h12C, 0); wr(12'h128, 32'd12);
        idle(3);
        wr(12'h010, 32'h1);
        n = 0; nl = 0; v = '0; v2 = '0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (msg_valid[1]) begin n++; v = msg_data[63:32]; v2 = msg_addr[63:32]; end
            if (irq_line[1]) nl++;
        end
        chk("R10 one message", 64'(n), 64'd1);
        chk("R10 data", 64'(v), 64'hDEAD0001);
        chk("R10 address", 64'(v2), 64'hFEE00010);
        chk("R10 no line", 64'(nl), 64'd0);

        // R7 32-bit mode wrap
        wr(12'h010, 0);
        wr(12'h120, 32'h104); wr(12'h0F4, 32'd5); wr(12'h0F0, 32'hFFFFFFF0);
        wr(12'h128, 32'd8);
        idle(3);
        wr(12'h010, 32'h1);
        bus_addr = 12'h0F0; n = 0; at = '0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (irq_line[1]) begin n++; at = bus_rdata; end
        end
        wr(12'h010, 0);
        chk("R7 wrap fires", 64'(n), 64'd1);
        chk("R7 match low", 64'(at), 64'd9);
        rd(12'h0F4, v); chk("R7 high word", 64'(v), 64'd6);

        // R11 rtc routing
        wr(12'h0F4, 0); wr(12'h0F0, 0);
        wr(12'h120, 32'h4); wr(12'h128, 32'd5);
        idle(3);
        wr(12'h010, 32'h3);
        n = 0; nl = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (legacy_rtc_irq) n++;
            if (irq_line[1]) nl++;
        end
        chk("R11 rtc pulse", 64'(n), 64'd1);
        chk("R11 line1 quiet", 64'(nl), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule